// File: doc/BRIEF.md
# Idle Mode Clock Controller

This block manages the idle power-saving state of a small 8-bit microcontroller. It runs from the free-running oscillator clock and produces registered clock-enable signals. The CPU and each peripheral clock domain use these enables to gate their flops; no clock is gated in this block. Software puts the controller into idle by writing a one to the idle bit of a power-control register. From the next clock edge the CPU clock enable is withheld. The CPU's registers keep their contents because they stop receiving enabled edges and are never reset.

While idle, the interrupt logic, serial port, A/D converter, capture/compare unit and general timers keep their clock enables. The watchdog is the one domain whose enable is removed automatically. Idle ends in one of two ways. The first is any interrupt request whose matching enable bit is set: the CPU enable returns, the wake interrupt can be serviced, and the idle bit clears itself. The second is a hardware reset. An idle status output mirrors the internal state cycle by cycle.

Top module: `idle_clkctl`

## Requirements
- R1: After reset, `idle_o` is 0, `cpu_ce` is 1, every bit of `dom_ce` is 1 and `reg_rd_data` is 0.
- R2: When `reg_wr_en` is high with `reg_wr_data[0]` = 1 at a rising edge, and no wake request is present, `idle_o` becomes 1 and `cpu_ce` becomes 0 after that edge. `cpu_ce` stays 1 during the write cycle itself.
- R3: While idle, the `dom_ce` bits for interrupt logic (bit 0), serial port (bit 1), A/D converter (bit 2), capture/compare (bit 3) and timers (bit 4) stay 1.
- R4: The watchdog enable `dom_ce[5]` is 0 exactly while idle and 1 otherwise.
- R5: While idle, a rising edge with `(irq_req & irq_en)` nonzero ends idle at that edge. `idle_o` then reads 0, and `cpu_ce` and `dom_ce[5]` read 1.
- R6: A request on `irq_req` whose `irq_en` bit is 0 does not end idle.
- R7: `reg_rd_data[0]` reads 1 while idle and 0 after the wake edge. Bits 7:1 always read 0.
- R8: An idle write in the same cycle as an enabled interrupt request does not enter idle.
- R9: A write with `reg_wr_data[0]` = 0 does not enter idle, whatever the other bits hold. A write that arrives while already idle leaves idle unchanged.
- R10: Asserting `rst_n` low ends idle at once, without waiting for a clock edge.
- R11: `cpu_ce` is the inverse of `idle_o` in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr_en | input | 1 | Write strobe for the power-control register |
| reg_wr_data | input | 8 | Write data; bit 0 is the idle request |
| reg_rd_data | output | 8 | Read-back of the power-control register |
| irq_req | input | 8 | Pending interrupt requests |
| irq_en | input | 8 | Per-source interrupt enables |
| cpu_ce | output | 1 | Registered CPU clock enable |
| dom_ce | output | 6 | Registered peripheral clock enables, index per domain |
| idle_o | output | 1 | Idle state flag |

## Verification
The bench checks that the CPU enable is still high during the cycle that writes the idle bit and falls only after that edge. A design that gated too early would lose the write, and one that gated too late would run one extra CPU cycle. It presents an interrupt that is pending but disabled, which a design that ignored the enable mask would take as a wake. It also writes the idle bit in the same cycle as an enabled request; a design that let entry win would sleep through the interrupt. Further tests cover reserved-bit-only writes, the self-clearing read-back after wake, the watchdog enable tracking idle while the other domains stay on, and an asynchronous reset issued mid-idle.

// File: rtl/idle_pkg.sv
package idle_pkg;

  localparam int REG_W    = 8;
  localparam int IDLE_BIT = 0;

  typedef enum logic [2:0] {
    DOM_INTR   = 3'd0,
    DOM_SERIAL = 3'd1,
    DOM_ADC    = 3'd2,
    DOM_CAPCOM = 3'd3,
    DOM_TIMER  = 3'd4,
    DOM_WDT    = 3'd5
  } dom_e;

  localparam int NUM_DOM = 6;

  // Domains whose clock enable is withdrawn during idle.
  localparam logic [NUM_DOM-1:0] STOP_IN_IDLE = NUM_DOM'(1) << DOM_WDT;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_IDLE = 1'b1
  } pwr_state_e;

endpackage

// File: rtl/idle_rst_sync.sv
module idle_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               wake
);

  logic [NUM_IRQ-1:0] live;

  always_comb begin
    live = irq_req & irq_en;
    wake = |live;
  end

endmodule

// File: rtl/idle_state.sv
module idle_state
  import idle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_idle,
  input  logic wake,
  output logic idle_q,
  output logic idle_nxt
);

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (wr_en && wr_idle && !wake) state_d = ST_IDLE;
      ST_IDLE: if (wake) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  assign idle_q   = (state_q == ST_IDLE);
  assign idle_nxt = (state_d == ST_IDLE);

  AST_ENTER_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && wr_en && wr_idle && !wake) |=> idle_q);  // R2

  AST_WAKE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && wake) |=> !idle_q);  // R5

  AST_STAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !wake) |=> idle_q);  // R6

  AST_CANCEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && wake) |=> !idle_q);  // R8

  AST_NO_ZERO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && !(wr_en && wr_idle)) |=> !idle_q);  // R9

endmodule

// File: rtl/idle_ce_gen.sv
module idle_ce_gen #(
  parameter int                 NUM_DOM   = 6,
  parameter logic [NUM_DOM-1:0] STOP_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_nxt,
  output logic               cpu_ce,
  output logic [NUM_DOM-1:0] dom_ce
);

  logic               cpu_ce_d;
  logic [NUM_DOM-1:0] dom_ce_d;

  always_comb begin
    cpu_ce_d = !idle_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_ce <= 1'b1;
    end else begin
      cpu_ce <= cpu_ce_d;
    end
  end

  for (genvar gi = 0; gi < NUM_DOM; gi++) begin : g_dom
    if (STOP_MASK[gi]) begin : g_stop
      always_comb dom_ce_d[gi] = !idle_nxt;
    end else begin : g_keep
      always_comb dom_ce_d[gi] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dom_ce[gi] <= 1'b1;
      end else begin
        dom_ce[gi] <= dom_ce_d[gi];
      end
    end
  end

endmodule

// File: rtl/idle_clkctl.sv
module idle_clkctl
  import idle_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [REG_W-1:0]   reg_wr_data,
  output logic [REG_W-1:0]   reg_rd_data,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               cpu_ce,
  output logic [NUM_DOM-1:0] dom_ce,
  output logic               idle_o
);

  logic rst_n_int;
  logic wake;
  logic idle_q;
  logic idle_nxt;
  logic wr_data_unused;

  // Reserved register bits carry no function; writes to them are dropped.
  assign wr_data_unused = ^reg_wr_data;

  idle_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  idle_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .wake    (wake)
  );

  idle_state u_state (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (reg_wr_en),
    .wr_idle  (reg_wr_data[IDLE_BIT]),
    .wake     (wake),
    .idle_q   (idle_q),
    .idle_nxt (idle_nxt)
  );

  idle_ce_gen #(.NUM_DOM(NUM_DOM), .STOP_MASK(STOP_IN_IDLE)) u_ce (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .idle_nxt (idle_nxt),
    .cpu_ce   (cpu_ce),
    .dom_ce   (dom_ce)
  );

  always_comb begin
    reg_rd_data           = '0;
    reg_rd_data[IDLE_BIT] = idle_q;
  end

  assign idle_o = idle_q;

  AST_CPU_CE_INV: assert property (@(posedge clk) disable iff (!rst_n_int)
    cpu_ce == !idle_o);  // R11

  AST_KEEP_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (dom_ce & ~STOP_IN_IDLE) == ~STOP_IN_IDLE);  // R3

  AST_WDT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n_int)
    dom_ce[DOM_WDT] == !idle_o);  // R4

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_rd_data[REG_W-1:1] == '0);  // R7

endmodule

// File: tb/idle_clkctl_bench.sv
module idle_clkctl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en;
  logic [7:0] reg_wr_data;
  logic [7:0] reg_rd_data;
  logic [7:0] irq_req;
  logic [7:0] irq_en;
  logic       cpu_ce;
  logic [5:0] dom_ce;
  logic       idle_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  idle_clkctl u_idle_clkctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .cpu_ce      (cpu_ce),
    .dom_ce      (dom_ce),
    .idle_o      (idle_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    reg_wr_en = 0; reg_wr_data = 0; irq_req = 0; irq_en = 0;
    rst_n = 0;
    repeat (2) tick();
    rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic enter_idle();
    reg_wr_en = 1; reg_wr_data = 8'h01;
    tick();
    reg_wr_en = 0; reg_wr_data = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 idle_o", idle_o, 0);
    chk("R1 cpu_ce", cpu_ce, 1);
    chk("R1 dom_ce", dom_ce, 6'h3f);
    chk("R1 rd_data", reg_rd_data, 0);
  endtask

  task automatic t_enter();
    reg_wr_en = 1; reg_wr_data = 8'h01;
    chk("R2 cpu_ce in write cycle", cpu_ce, 1);
    tick();
    reg_wr_en = 0; reg_wr_data = 0;
    chk("R2 idle_o after write", idle_o, 1);
    chk("R2 cpu_ce after write", cpu_ce, 0);
    chk("R11 cpu_ce inverse", cpu_ce, !idle_o);
    chk("R3 kept domains", dom_ce[4:0], 5'h1f);
    chk("R4 wdt stopped", dom_ce[5], 0);
    chk("R7 rd idle bit", reg_rd_data, 8'h01);
    repeat (3) tick();
    chk("R3 kept domains later", dom_ce[4:0], 5'h1f);
  endtask

  task automatic t_disabled_irq();
    irq_req = 8'h24; irq_en = 8'h81;
    repeat (3) tick();
    chk("R6 stays idle", idle_o, 1);
    chk("R6 cpu_ce off", cpu_ce, 0);
    irq_req = 0; irq_en = 0;
  endtask

  task automatic t_ignore_write_idle();
    reg_wr_en = 1; reg_wr_data = 8'h00;
    tick();
    reg_wr_en = 0;
    chk("R9 write while idle", idle_o, 1);
  endtask

  task automatic t_wake();
    irq_req = 8'h10; irq_en = 8'h10;
    chk("R5 still idle before edge", idle_o, 1);
    tick();
    irq_req = 0; irq_en = 0;
    chk("R5 idle_o cleared", idle_o, 0);
    chk("R5 cpu_ce back", cpu_ce, 1);
    chk("R5 wdt back", dom_ce[5], 1);
    chk("R7 self clear", reg_rd_data, 0);
    tick();
    chk("R11 after wake", cpu_ce, !idle_o);
  endtask

  task automatic t_cancel();
    irq_req = 8'h02; irq_en = 8'hff;
    reg_wr_en = 1; reg_wr_data = 8'h01;
    tick();
    reg_wr_en = 0; reg_wr_data = 0; irq_req = 0; irq_en = 0;
    chk("R8 entry cancelled", idle_o, 0);
    chk("R8 cpu_ce kept", cpu_ce, 1);
  endtask

  task automatic t_zero_write();
    reg_wr_en = 1; reg_wr_data = 8'hfe;
    tick();
    reg_wr_en = 0; reg_wr_data = 0;
    chk("R9 zero bit write", idle_o, 0);
    chk("R7 reserved bits", reg_rd_data, 0);
    reg_wr_en = 0; reg_wr_data = 8'h01;
    tick();
    chk("R9 no strobe", idle_o, 0);
    reg_wr_data = 0;
  endtask

  task automatic t_async_reset();
    enter_idle();
    chk("R10 idle before reset", idle_o, 1);
    #1 rst_n = 0;
    #0.5;
    chk("R10 async idle_o", idle_o, 0);
    chk("R10 async cpu_ce", cpu_ce, 1);
    chk("R10 async wdt", dom_ce[5], 1);
    @(negedge clk);
    rst_n = 1;
    repeat (3) tick();
    chk("R1 after reset release", idle_o, 0);
  endtask

  initial begin
    t_reset();
    t_enter();
    t_disabled_irq();
    t_ignore_write_idle();
    t_wake();
    t_cancel();
    t_zero_write();
    enter_idle();
    chk("R2 second entry", idle_o, 1);
    t_wake();
    t_async_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule